// File: doc/BRIEF.md
# Page-Bounded Serial Character DMA

This engine moves characters between system memory and channel A of a serial controller, one character per 32-bit memory word. A one-cycle start pulse supplies a byte address and a direction. In the send direction the engine fetches a word, forwards the byte held in bits [15:8] to the transmitter, and moves on to the next word. It stops once it has consumed the last word of the current 4 KiB page. It can also copy every sent byte back into the channel's receive FIFO for loopback testing.

In the receive direction the engine pops characters from the receive FIFO. It writes each one to memory with the character repeated in all four byte lanes. It stops when the FIFO runs dry or when it has filled the last word of the current 2 KiB half page. When a transfer ends, a one-cycle completion strobe reports how many bytes the transfer covered.

The memory side is a word-wide port with a request/grant handshake and a separate response strobe. Only one word is in flight at a time. Arbitration and interrupt signalling belong to the surrounding system.

Top module: `serial_page_dma`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `memReq`, `txValid`, `fifoPop`, `fifoPush` and `doneStrobe` are 0 and `doneCount` is 0.
- R2: A start pulse seen while idle latches `startAddr` with bits [1:0] forced to zero and latches `startRx`: 0 selects send mode, 1 selects receive mode.
- R3: In send mode each step issues a read (`memWe`=0) of the current word address and offers bits [15:8] of the returned word on `txByte`.
- R4: After each sent byte the address grows by 4. The send transfer ends after the word whose incremented address has bits [11:2] equal to zero. At least one word is always sent, and from start address A the count of words is 1024 minus A[11:2].
- R5: When `loopEn` is 1 at the moment a byte is accepted by the transmitter (`txValid` and `txReady`), the same byte is pushed on `fifoPushData` with `fifoPush`=1 in that cycle.
- R6: In receive mode each step pops one character (`fifoPop`) and writes it to the current word address (`memWe`=1) with the character in all four byte lanes. The address then grows by 4.
- R7: A receive transfer ends when the FIFO is empty at the start of a step, or after the word whose incremented address has bits [10:2] equal to zero. A start with an empty FIFO writes nothing.
- R8: `doneCount` equals the number of bytes sent for a send transfer, and four times the number of words written for a receive transfer. It holds its value until the next accepted start.
- R9: `doneStrobe` is 1 for exactly one cycle per transfer, and `busy` is 0 in the cycle after it.
- R10: A start pulse while `busy` is 1 is ignored. The running transfer completes unchanged and no second transfer follows.
- R11: `memReq` stays 1 with a stable address until `memGnt`. After a grant the engine drops `memReq` and issues nothing until `memRvalid`.
- R12: `txByte` is stable while `txValid` waits for `txReady`, and `fifoPop` is never 1 while `fifoEmpty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle transfer start |
| startAddr | input | AW | Byte address of the first word |
| startRx | input | 1 | 1 = receive to memory, 0 = send from memory |
| loopEn | input | 1 | Copy sent bytes into the receive FIFO |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | AW | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memGnt | input | 1 | Request accepted |
| memRvalid | input | 1 | Response (read data or write acknowledge) |
| memRdata | input | 32 | Read data |
| txValid | output | 1 | Byte offered to transmitter |
| txByte | output | 8 | Byte to transmit |
| txReady | input | 1 | Transmitter accepts byte |
| fifoEmpty | input | 1 | Receive FIFO has no character |
| fifoData | input | 8 | Head character of receive FIFO |
| fifoPop | output | 1 | Remove head character |
| fifoPush | output | 1 | Loopback write into receive FIFO |
| fifoPushData | output | 8 | Loopback character |
| busy | output | 1 | Transfer in progress |
| doneStrobe | output | 1 | Transfer finished (one cycle) |
| doneCount | output | PAGE_BITS+1 | Byte count of the last transfer |

## Verification
Every result is due at a fixed distance from the handshake that causes it. A read or write request is granted on a cycle edge, and the response returns one cycle later. A sent byte appears on `txByte` the cycle after the read response. `doneStrobe` rises the cycle after the last transmitter handshake or last write response, and `busy` falls one cycle later. The bench's memory, FIFO and transmitter models log every handshake on the clock edge, and the checks read those logs and the outputs only at falling edges once `doneStrobe` is seen. Grant and ready toggle on different periods, so every wait state and hold condition is exercised.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef struct packed {
    logic load;
    logic capMem;
    logic capFifo;
    logic advance;
  } spdStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_TX_SEND,
    ST_RX_CHECK,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_FIN
  } spdState_t;

endpackage

// File: rtl/spd_datapath.sv
module spd_datapath
  import spd_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int HALF_BITS = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  spdStrobe_t           strb,
  input  logic [AW-1:0]        startAddr,
  input  logic                 startRx,
  input  logic [7:0]           rdLane,
  input  logic [7:0]           fifoData,
  output logic [AW-1:0]        addrQ,
  output logic [7:0]           byteQ,
  output logic [PAGE_BITS:0]   countQ,
  output logic                 dirRxQ,
  output logic                 wrapTx,
  output logic                 wrapRx
);
  localparam int CW = PAGE_BITS + 1;

  logic [AW-1:0] nextAddr;

  assign nextAddr = addrQ + AW'(4);
  assign wrapTx   = (nextAddr[PAGE_BITS-1:2] == '0);
  assign wrapRx   = (nextAddr[HALF_BITS-1:2] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      byteQ  <= '0;
      countQ <= '0;
      dirRxQ <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ  <= {startAddr[AW-1:2], 2'b00};
        countQ <= '0;
        dirRxQ <= startRx;
      end
      if (strb.capMem)  byteQ <= rdLane;
      if (strb.capFifo) byteQ <= fifoData;
      if (strb.advance) begin
        addrQ  <= nextAddr;
        countQ <= countQ + (dirRxQ ? CW'(4) : CW'(1));
      end
    end
  end

  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (addrQ[1:0] == 2'b00) && (countQ != '0)) else $error("advance step"); // R8

endmodule

// File: rtl/spd_ctrl.sv
module spd_ctrl
  import spd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       startRx,
  input  logic       loopEn,
  input  logic       memGnt,
  input  logic       memRvalid,
  input  logic       txReady,
  input  logic       fifoEmpty,
  input  logic       wrapTx,
  input  logic       wrapRx,
  output spdStrobe_t strb,
  output logic       memReq,
  output logic       memWe,
  output logic       txValid,
  output logic       fifoPop,
  output logic       fifoPush,
  output logic       doneStrobe,
  output logic       busy
);
  spdState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    case (stateQ)
      ST_IDLE: if (startPulse) begin
        strb.load = 1'b1;
        stateD    = startRx ? ST_RX_CHECK : ST_RD_REQ;
      end
      ST_RD_REQ:  if (memGnt) stateD = ST_RD_WAIT;
      ST_RD_WAIT: if (memRvalid) begin
        strb.capMem = 1'b1;
        stateD      = ST_TX_SEND;
      end
      ST_TX_SEND: if (txReady) begin
        strb.advance = 1'b1;
        stateD       = wrapTx ? ST_FIN : ST_RD_REQ;
      end
      ST_RX_CHECK: begin
        if (fifoEmpty) stateD = ST_FIN;
        else begin
          strb.capFifo = 1'b1;
          stateD       = ST_WR_REQ;
        end
      end
      ST_WR_REQ:  if (memGnt) stateD = ST_WR_WAIT;
      ST_WR_WAIT: if (memRvalid) begin
        strb.advance = 1'b1;
        stateD       = wrapRx ? ST_FIN : ST_RX_CHECK;
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign memReq     = (stateQ == ST_RD_REQ) || (stateQ == ST_WR_REQ);
  assign memWe      = (stateQ == ST_WR_REQ);
  assign txValid    = (stateQ == ST_TX_SEND);
  assign fifoPop    = (stateQ == ST_RX_CHECK) && !fifoEmpty;
  assign fifoPush   = txValid && txReady && loopEn;
  assign doneStrobe = (stateQ == ST_FIN);
  assign busy       = (stateQ != ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe && !busy) else $error("done width"); // R9
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty) else $error("pop on empty"); // R12
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memGnt) |=> !memReq) else $error("second request"); // R11
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && !doneStrobe) |=> busy) else $error("start disturbed"); // R10

endmodule

// File: rtl/serial_page_dma.sv
module serial_page_dma
  import spd_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int HALF_BITS = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startPulse,
  input  logic [AW-1:0]        startAddr,
  input  logic                 startRx,
  input  logic                 loopEn,
  output logic                 memReq,
  output logic                 memWe,
  output logic [AW-1:0]        memAddr,
  output logic [31:0]          memWdata,
  input  logic                 memGnt,
  input  logic                 memRvalid,
  input  logic [31:0]          memRdata,
  output logic                 txValid,
  output logic [7:0]           txByte,
  input  logic                 txReady,
  input  logic                 fifoEmpty,
  input  logic [7:0]           fifoData,
  output logic                 fifoPop,
  output logic                 fifoPush,
  output logic [7:0]           fifoPushData,
  output logic                 busy,
  output logic                 doneStrobe,
  output logic [PAGE_BITS:0]   doneCount
);
  spdStrobe_t strb;
  logic [AW-1:0] addrQ;
  logic [7:0]    byteQ;
  logic          dirRxQ, wrapTx, wrapRx;
  logic          unusedBits;

  assign unusedBits = ^{memRdata[31:16], memRdata[7:0], dirRxQ};

  spd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startRx(startRx),
    .loopEn(loopEn), .memGnt(memGnt), .memRvalid(memRvalid),
    .txReady(txReady), .fifoEmpty(fifoEmpty), .wrapTx(wrapTx),
    .wrapRx(wrapRx), .strb(strb), .memReq(memReq), .memWe(memWe),
    .txValid(txValid), .fifoPop(fifoPop), .fifoPush(fifoPush),
    .doneStrobe(doneStrobe), .busy(busy)
  );

  spd_datapath #(.AW(AW), .PAGE_BITS(PAGE_BITS), .HALF_BITS(HALF_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .startRx(startRx), .rdLane(memRdata[15:8]), .fifoData(fifoData),
    .addrQ(addrQ), .byteQ(byteQ), .countQ(doneCount), .dirRxQ(dirRxQ),
    .wrapTx(wrapTx), .wrapRx(wrapRx)
  );

  assign memAddr      = addrQ;
  assign memWdata     = {4{byteQ}};
  assign txByte       = byteQ;
  assign fifoPushData = byteQ;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> memReq && $stable(memAddr) && $stable(memWe)) else $error("req dropped"); // R11
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid && $stable(txByte)) else $error("tx unstable"); // R12
  AST_PUSH_ON_SEND: assert property (@(posedge clk) disable iff (!rstN)
    fifoPush |-> txValid && txReady && loopEn) else $error("stray push"); // R5
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startPulse) |=> $stable(doneCount)) else $error("count moved"); // R8

endmodule

// File: tb/serial_page_dma_tb_top.sv
module serial_page_dma_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  localparam logic [31:0] V_ADDR [NV] = '{32'h0FF0, 32'h2FFB, 32'h07F0, 32'h0100,
                                          32'h0200, 32'h1FF4, 32'h0FFE};
  localparam logic        V_RX   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam int          V_NCH  [NV] = '{0, 0, 6, 3, 0, 0, 2};
  localparam logic        V_LOOP [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  logic clk = 1'b0, rstN = 1'b0;
  logic startPulse = 1'b0, startRx = 1'b0, loopEn = 1'b0;
  logic [31:0] startAddr = '0;
  logic memReq, memWe, memGnt, memRvalid;
  logic [31:0] memAddr, memWdata, memRdata;
  logic txValid, txReady, fifoEmpty, fifoPop, fifoPush, busy, doneStrobe;
  logic [7:0] txByte, fifoData, fifoPushData;
  logic [12:0] doneCount;

  logic tbFlush = 1'b0, tbPush = 1'b0;
  logic [7:0] tbPushData = '0;
  logic gntPh, rdyPh;
  logic [1:0] rdyCnt;
  logic [5:0] head, tail;
  logic [7:0] fifoMem [64];
  logic [7:0] txLog [64];
  logic [31:0] wrAddrLog [64];
  logic [31:0] wrDataLog [64];
  int txN, wrN;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_page_dma dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startAddr(startAddr),
    .startRx(startRx), .loopEn(loopEn), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memGnt(memGnt),
    .memRvalid(memRvalid), .memRdata(memRdata), .txValid(txValid),
    .txByte(txByte), .txReady(txReady), .fifoEmpty(fifoEmpty),
    .fifoData(fifoData), .fifoPop(fifoPop), .fifoPush(fifoPush),
    .fifoPushData(fifoPushData), .busy(busy), .doneStrobe(doneStrobe),
    .doneCount(doneCount)
  );

  function automatic logic [31:0] memWord(logic [31:0] a);
    logic [7:0] i;
    i = a[9:2];
    return {i ^ 8'hD0, i ^ 8'hC3, i ^ 8'h5A, 8'h11};
  endfunction

  assign memGnt    = gntPh;
  assign txReady   = rdyPh;
  assign fifoEmpty = (head == tail);
  assign fifoData  = fifoMem[head];

  // Bench models: memory with one-cycle response, transmitter sink, receive FIFO.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    gntPh  <= rstN ? ~gntPh : 1'b0;
    rdyCnt <= (!rstN || rdyCnt == 2'd2) ? 2'd0 : rdyCnt + 2'd1;
    rdyPh  <= (rdyCnt != 2'd0);
    memRvalid <= 1'b0;
    if (memReq && memGnt) begin
      memRvalid <= 1'b1;
      memRdata  <= memWord(memAddr);
      if (memWe) begin
        wrAddrLog[wrN[5:0]] <= memAddr;
        wrDataLog[wrN[5:0]] <= memWdata;
        wrN <= wrN + 1;
      end
    end
    if (txValid && txReady) begin
      txLog[txN[5:0]] <= txByte;
      txN <= txN + 1;
    end
    if (fifoPop) head <= head + 6'd1;
    if (fifoPush) begin
      fifoMem[tail] <= fifoPushData;
      tail <= tail + 6'd1;
    end else if (tbPush) begin
      fifoMem[tail] <= tbPushData;
      tail <= tail + 6'd1;
    end
    if (tbFlush || !rstN) begin
      head <= '0; tail <= '0; txN <= 0; wrN <= 0;
    end
  end

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic startXfer(input logic [31:0] a, input logic rx);
    startAddr = a; startRx = rx; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitDone(output logic seen);
    seen = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (doneStrobe) begin seen = 1'b1; break; end
    end
    if (!seen) check(1'b0, "R9 done timeout", 0, 1);
  endtask

  initial begin
    logic seen;
    logic [31:0] base;
    int expW, expC;
    gntPh = 1'b0; rdyCnt = '0; rdyPh = 1'b0; memRvalid = 1'b0; memRdata = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check(!busy && !memReq && !txValid && !fifoPop && !fifoPush && !doneStrobe && doneCount == 0,
          "R1 reset", {busy, memReq, txValid, fifoPop, doneStrobe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !memReq && !txValid && doneCount == 0, "R1 after reset", doneCount, 0);

    for (int v = 0; v < NV; v++) begin
      tbFlush = 1'b1; @(negedge clk); tbFlush = 1'b0;
      for (int i = 0; i < V_NCH[v]; i++) begin
        tbPush = 1'b1; tbPushData = 8'(8'h30 + v * 16 + i); @(negedge clk);
      end
      tbPush = 1'b0;
      loopEn = V_LOOP[v];
      base = {V_ADDR[v][31:2], 2'b00};
      if (V_RX[v]) begin
        expW = 512 - int'(base[10:2]);
        if (V_NCH[v] < expW) expW = V_NCH[v];
        expC = 4 * expW;
      end else begin
        expW = 1024 - int'(base[11:2]);
        expC = expW;
      end
      startXfer(V_ADDR[v], V_RX[v]);
      waitDone(seen);
      check(doneCount == 13'(expC), V_RX[v] ? "R8 rx count" : "R8 tx count", doneCount, expC);
      if (V_RX[v]) begin
        // R6/R7: words written, lanes replicated, addresses stepped, stop point
        check(wrN == expW && txN == 0, "R7 rx words", wrN, expW);
        for (int k = 0; k < expW; k++) begin
          check(wrAddrLog[k] == base + 32'(4 * k), "R6 rx addr", wrAddrLog[k], base + 32'(4 * k));
          check(wrDataLog[k] == {4{8'(8'h30 + v * 16 + k)}}, "R6 rx data",
                wrDataLog[k], {4{8'(8'h30 + v * 16 + k)}});
        end
        check(int'(6'(tail - head)) == V_NCH[v] - expW, "R7 fifo left",
              6'(tail - head), V_NCH[v] - expW);
      end else begin
        // R2/R3/R4: aligned address, lane 1 sent, page stop
        check(txN == expW && wrN == 0, "R4 tx words", txN, expW);
        for (int k = 0; k < expW; k++)
          check(txLog[k] == memWord(base + 32'(4 * k))[15:8], "R3 tx byte",
                txLog[k], memWord(base + 32'(4 * k))[15:8]);
        // R5: loopback copies each sent byte into the FIFO
        check(int'(6'(tail - head)) == (V_LOOP[v] ? expW : 0), "R5 loop count",
              6'(tail - head), V_LOOP[v] ? expW : 0);
        if (V_LOOP[v])
          for (int k = 0; k < expW; k++)
            check(fifoMem[k] == memWord(base + 32'(4 * k))[15:8], "R5 loop byte",
                  fifoMem[k], memWord(base + 32'(4 * k))[15:8]);
      end
      @(negedge clk);
      // R9: single-cycle strobe, busy drops
      check(!doneStrobe && !busy, "R9 done width", {doneStrobe, busy}, 0);
      repeat (3) @(negedge clk);
      check(doneCount == 13'(expC), "R8 count held", doneCount, expC);
    end

    // R10: start while busy is ignored
    tbFlush = 1'b1; @(negedge clk); tbFlush = 1'b0;
    tbPush = 1'b1; tbPushData = 8'hEE; @(negedge clk); tbPush = 1'b0;
    loopEn = 1'b0;
    startXfer(32'h0FF8, 1'b0);
    repeat (2) @(negedge clk);
    startXfer(32'h0100, 1'b1);
    waitDone(seen);
    check(doneCount == 13'd2 && txN == 2 && wrN == 0, "R10 busy start ignored", doneCount, 2);
    repeat (6) @(negedge clk);
    check(!busy && !memReq && wrN == 0, "R10 no second transfer", {busy, memReq}, 0);
    check(int'(6'(tail - head)) == 1, "R10 fifo untouched", 6'(tail - head), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule